// File: doc/BRIEF.md
# Four-Bit Lookahead Adder-Subtractor with Corrected Results

This block adds or subtracts two 4-bit operands on one shared datapath. A single mode input selects the operation. In subtract mode the second operand is inverted bit by bit and a carry of one enters bit 0, so the adder forms the two's complement of that operand. Every carry, including the end carry, comes from a two-level lookahead network built from per-bit generate and propagate terms. No carry waits for a lower carry to settle.

Besides the raw 4-bit result and the end carry, the block reports three flags:

- unsigned overflow on addition;
- a negative flag for unsigned subtraction when the first operand is the smaller one;
- signed overflow, taken from the carry into and out of the top bit.

It also gives two corrected forms of the answer. The first is a 5-bit two's-complement result that stays exact even when the 4-bit signed result overflows. The second is a magnitude that pairs with the negative flag for unsigned subtraction.

A registered output stage, selected by a parameter and on by default, puts one clock of latency on all results. This lets the lookahead path be timed between registers.

Top module: `addsub_cla_top`

## Requirements
- R1: With sub_mode=0, res_sum equals (opa+opb) mod 16 and res_carry is bit 4 of the unsigned sum opa+opb.
- R2: With sub_mode=1, res_sum equals (opa-opb) mod 16 and res_carry is 1 exactly when opa >= opb as unsigned values.
- R3: flag_uovf is 1 exactly when sub_mode=0 and the unsigned sum opa+opb exceeds 15.
- R4: flag_neg is 1 exactly when sub_mode=1 and opa < opb (unsigned). In subtract mode, res_mag equals |opa-opb|. In add mode, res_mag equals res_sum.
- R5: With opa and opb read as 4-bit two's complement (-8..+7), flag_sovf is 1 exactly when the true signed result of opa+opb (sub_mode=0) or opa-opb (sub_mode=1) lies outside -8..+7.
- R6: res_wide holds the true signed result of R5 as a 5-bit two's-complement value (-16..+15). Its low 4 bits always equal res_sum.
- R7: With the default registered stage, all outputs change only at a rising clock edge. They show the result of the inputs present at that edge, one cycle of latency.
- R8: While rst_n is low, every output is zero, and this takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa | input | 4 | First operand |
| opb | input | 4 | Second operand |
| sub_mode | input | 1 | 0 selects opa+opb, 1 selects opa-opb |
| res_sum | output | 4 | Raw 4-bit result |
| res_carry | output | 1 | End carry out of bit 3 |
| flag_uovf | output | 1 | Unsigned addition overflow |
| flag_neg | output | 1 | Unsigned subtraction went negative (opa < opb) |
| flag_sovf | output | 1 | Signed overflow |
| res_wide | output | 5 | Exact signed result, 5-bit two's complement |
| res_mag | output | 4 | Magnitude paired with flag_neg |

## Verification
The bench sweeps every operand and mode pair, so it covers each corner that might be mishandled:

- Equal operands in subtract mode. A design that derived the borrow from the wrong carry polarity would flag a difference of zero as negative.
- The signed extremes, such as -8-1, 7+7 and 0-(-8). Taking the fifth bit from the old MSB instead of the end carry would give the wrong sign in res_wide.
- A carry-in missing from the lookahead terms. This would leave subtraction off by one, seen in 15-12 and 12-15.

Separate scenarios check that outputs hold until the next rising edge and that reset clears them between edges.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  localparam int DATA_W = 4;
  localparam int WIDE_W = DATA_W + 1;

  typedef struct packed {
    logic [DATA_W-1:0] sum;
    logic              carry;
    logic              uovf;
    logic              neg;
    logic              sovf;
    logic [WIDE_W-1:0] wide;
    logic [DATA_W-1:0] mag;
  } addsub_res_t;

endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep
  import addsub_pkg::*;
(
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              sub_mode,
  output logic [DATA_W-1:0] gen,
  output logic [DATA_W-1:0] prop
);

  logic [DATA_W-1:0] opb_eff;

  // conditional inversion of the second operand; the +1 enters as carry-in
  assign opb_eff = opb ^ {DATA_W{sub_mode}};
  assign gen     = opa & opb_eff;
  assign prop    = opa ^ opb_eff;

endmodule

// File: rtl/addsub_lookahead.sv
module addsub_lookahead
  import addsub_pkg::*;
(
  input  logic [DATA_W-1:0] gen,
  input  logic [DATA_W-1:0] prop,
  input  logic              cin,
  output logic [DATA_W:0]   carry
);

  // Each carry is a flat OR of AND terms over gen/prop/cin: two logic levels.
  always_comb begin
    logic acc;
    logic term;
    carry[0] = cin;
    for (int i = 1; i <= DATA_W; i++) begin
      term = cin;
      for (int j = 0; j < i; j++) term = term & prop[j];
      acc = term;
      for (int k = 0; k < i; k++) begin
        term = gen[k];
        for (int j = k + 1; j < i; j++) term = term & prop[j];
        acc = acc | term;
      end
      carry[i] = acc;
    end
  end

endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
  import addsub_pkg::*;
(
  input  logic [DATA_W-1:0] prop,
  input  logic [DATA_W:0]   carry,
  input  logic              sub_mode,
  output addsub_res_t       res
);

  logic [DATA_W-1:0] sum;
  logic              end_c;
  logic              msb_c;
  logic              sovf;
  logic              neg;

  assign sum   = prop ^ carry[DATA_W-1:0];
  assign end_c = carry[DATA_W];
  assign msb_c = carry[DATA_W-1];
  assign sovf  = end_c ^ msb_c;
  assign neg   = sub_mode & ~end_c;

  always_comb begin
    res.sum   = sum;
    res.carry = end_c;
    res.uovf  = ~sub_mode & end_c;
    res.neg   = neg;
    res.sovf  = sovf;
    // on overflow the end carry becomes the sign and the old MSB a magnitude bit
    res.wide  = sovf ? {end_c, sum} : {sum[DATA_W-1], sum};
    res.mag   = neg ? ((~sum) + {{(DATA_W-1){1'b0}}, 1'b1}) : sum;
  end

endmodule

// File: rtl/addsub_out_stage.sv
module addsub_out_stage
  import addsub_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
)(
  input  logic        clk,
  input  logic        rst_n,
  input  addsub_res_t d,
  output addsub_res_t q
);

  generate
    if (REG_OUT) begin : g_reg
      addsub_res_t res_nxt;
      addsub_res_t res_q;

      always_comb begin
        res_nxt = d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_nxt;
      end

      assign q = res_q;
    end else begin : g_comb
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/addsub_cla_top.sv
module addsub_cla_top
  import addsub_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              sub_mode,
  output logic [DATA_W-1:0] res_sum,
  output logic              res_carry,
  output logic              flag_uovf,
  output logic              flag_neg,
  output logic              flag_sovf,
  output logic [WIDE_W-1:0] res_wide,
  output logic [DATA_W-1:0] res_mag
);

  logic [DATA_W-1:0] gen;
  logic [DATA_W-1:0] prop;
  logic [DATA_W:0]   carry;
  addsub_res_t       comb_res;
  addsub_res_t       out_res;

  addsub_operand_prep i_prep (
    .opa(opa), .opb(opb), .sub_mode(sub_mode), .gen(gen), .prop(prop)
  );

  addsub_lookahead i_cla (
    .gen(gen), .prop(prop), .cin(sub_mode), .carry(carry)
  );

  addsub_flags i_flags (
    .prop(prop), .carry(carry), .sub_mode(sub_mode), .res(comb_res)
  );

  addsub_out_stage #(.REG_OUT(REG_OUT)) i_out (
    .clk(clk), .rst_n(rst_n), .d(comb_res), .q(out_res)
  );

  assign res_sum   = out_res.sum;
  assign res_carry = out_res.carry;
  assign flag_uovf = out_res.uovf;
  assign flag_neg  = out_res.neg;
  assign flag_sovf = out_res.sovf;
  assign res_wide  = out_res.wide;
  assign res_mag   = out_res.mag;

endmodule

// File: rtl/addsub_chk.sv
module addsub_chk
  import addsub_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic              sub_mode,
  input logic [DATA_W-1:0] res_sum,
  input logic              res_carry,
  input logic              flag_uovf,
  input logic              flag_neg,
  input logic              flag_sovf,
  input logic [WIDE_W-1:0] res_wide,
  input logic [DATA_W-1:0] res_mag
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1 R2 R7
  sum_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> res_sum == DATA_W'($past(opa) +
      ($past(sub_mode) ? (DATA_W'(0) - $past(opb)) : $past(opb))));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> !(flag_uovf && flag_neg));

  // R3
  uovf_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && flag_uovf) |-> (res_carry && !$past(sub_mode)));

  // R4
  neg_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && flag_neg) |-> (DATA_W'(res_mag + res_sum) == '0 && !res_carry));

  // R4
  pos_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !flag_neg) |-> res_mag == res_sum);

  // R6
  wide_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> res_wide[DATA_W-1:0] == res_sum);

  // R5 R6
  wide_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && flag_sovf) |-> res_wide[DATA_W] == res_carry);

  // R8
  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      reset_clear_chk: assert ({res_sum, res_carry, flag_uovf, flag_neg,
                                flag_sovf, res_wide, res_mag} == '0);
    end
  end

endmodule

bind addsub_cla_top addsub_chk i_addsub_chk (.*);

// File: tb/test_addsub_cla_top.sv
module test_addsub_cla_top;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [3:0] opa;
  logic [3:0] opb;
  logic       sub_mode;
  logic [3:0] res_sum;
  logic       res_carry;
  logic       flag_uovf;
  logic       flag_neg;
  logic       flag_sovf;
  logic [4:0] res_wide;
  logic [3:0] res_mag;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  addsub_cla_top i_addsub_cla_top (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .sub_mode(sub_mode),
    .res_sum(res_sum), .res_carry(res_carry), .flag_uovf(flag_uovf),
    .flag_neg(flag_neg), .flag_sovf(flag_sovf), .res_wide(res_wide),
    .res_mag(res_mag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input bit m);
    @(negedge clk);
    opa = 4'(a); opb = 4'(b); sub_mode = m;
    @(posedge clk);
    @(negedge clk);
  endtask

  // compare every output with integer arithmetic for the last applied inputs
  task automatic check_vec(input int a, input int b, input bit m);
    int sa, sb, sr, raw, e_sum, e_mag;
    bit e_c, e_uovf, e_neg, e_sovf;
    raw    = m ? (a - b) : (a + b);
    e_sum  = raw & 15;
    e_c    = m ? (a >= b) : (a + b > 15);
    e_uovf = !m && (a + b > 15);
    e_neg  = m && (a < b);
    e_mag  = m ? ((a >= b) ? a - b : b - a) : e_sum;
    sa     = (a >= 8) ? a - 16 : a;
    sb     = (b >= 8) ? b - 16 : b;
    sr     = m ? (sa - sb) : (sa + sb);
    e_sovf = (sr < -8) || (sr > 7);
    chk(m ? "R2" : "R1", $sformatf("sum %0d%s%0d", a, m ? "-" : "+", b), int'(res_sum), e_sum);
    chk(m ? "R2" : "R1", $sformatf("carry %0d,%0d,m%0d", a, b, m), int'(res_carry), int'(e_c));
    chk("R3", $sformatf("uovf %0d,%0d,m%0d", a, b, m), int'(flag_uovf), int'(e_uovf));
    chk("R4", $sformatf("neg %0d,%0d,m%0d", a, b, m), int'(flag_neg), int'(e_neg));
    chk("R4", $sformatf("mag %0d,%0d,m%0d", a, b, m), int'(res_mag), e_mag);
    chk("R5", $sformatf("sovf %0d,%0d,m%0d", a, b, m), int'(flag_sovf), int'(e_sovf));
    chk("R6", $sformatf("wide %0d,%0d,m%0d", a, b, m), int'(res_wide), sr & 31);
  endtask

  task automatic all_zero(input string tag);
    chk("R8", {tag, " outputs"}, int'({res_sum, res_carry, flag_uovf, flag_neg,
                                       flag_sovf, res_wide, res_mag}), 0);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; opa = 4'd12; opb = 4'd15; sub_mode = 1'b1;
    repeat (3) @(negedge clk);
    all_zero("power-on reset");
    rst_n = 1'b1;
  endtask

  task automatic test_demo();
    apply(12, 15, 1'b0); check_vec(12, 15, 1'b0);  // R1 R3 carry and overflow
    apply(15, 12, 1'b1); check_vec(15, 12, 1'b1);  // R2 end carry discarded
    apply(12, 15, 1'b1); check_vec(12, 15, 1'b1);  // R4 magnitude 3, negative
    chk("R4", "12-15 magnitude", int'(res_mag), 3);
  endtask

  task automatic test_signed_edges();
    apply(7, 7, 1'b0);  check_vec(7, 7, 1'b0);    // R5 R6: +14
    chk("R6", "7+7 wide", int'(res_wide), 14);
    apply(8, 1, 1'b1);  check_vec(8, 1, 1'b1);    // R5 R6: -9
    chk("R6", "-8-1 wide", int'(res_wide), 23);
    apply(0, 8, 1'b1);  check_vec(0, 8, 1'b1);    // R5 R6: +8
    apply(8, 8, 1'b0);  check_vec(8, 8, 1'b0);    // R5 R6: -16
    apply(5, 5, 1'b1);  check_vec(5, 5, 1'b1);    // R4: equal operands not negative
  endtask

  task automatic test_latency();
    apply(3, 4, 1'b0);
    @(negedge clk);
    opa = 4'd9; opb = 4'd2; sub_mode = 1'b1;
    #1;
    chk("R7", "held before edge", int'(res_sum), 7);
    @(posedge clk);
    #1;
    chk("R7", "updated after edge", int'(res_sum), 7);
  endtask

  task automatic test_async_reset();
    apply(15, 15, 1'b0);
    #2;
    rst_n = 1'b0;
    #1;
    all_zero("mid-cycle reset");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic test_sweep();
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          apply(a, b, bit'(m));
          check_vec(a, b, bit'(m));
        end
  endtask

  initial begin
    test_reset();
    test_demo();
    test_signed_edges();
    test_latency();
    test_async_reset();
    test_sweep();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule